// File: doc/BRIEF.md
# Buffered PWM Port Output Register

This block is a 7-bit output port. A pin register drives the port pins, and a write buffer sits in front of it. Each bit has its own mode, set by a mask input. A bit in general-purpose mode works as a normal output latch: a CPU write reaches its pin register bit on the same clock edge that loads the buffer. A bit in PWM mode holds its pin value through CPU writes. The written value waits in the buffer, and a transfer pulse from the timer moves it to the pin.

Writes and reads share one address. The CPU writes into the buffer, and a read returns the pin register, padded with zeros up to the bus width. A read therefore does not show a buffered PWM value that has not yet been transferred. For this reason, software must not use read-modify-write on this port. The timer produces the transfer pulse at a PWM period boundary, so all PWM pins change together.

Top module: `pwm_port_buf`

## Requirements
- R1: A synchronous active-high reset clears the buffer and the pin register to zero. After reset, `pin_out` and `rd_data` read 0.
- R2: When `wr_en` is high, every bit whose `pwm_mask` bit is 0 (general-purpose) takes `wr_data` at that clock edge. The new value shows on `pin_out` after that edge.
- R3: Without a transfer pulse, a write leaves every bit whose `pwm_mask` bit is 1 (PWM) unchanged on `pin_out`.
- R4: When `xfer_pulse` is high and `wr_en` is low, every PWM-mode bit of the pin register takes the matching buffer bit.
- R5: `xfer_pulse` has no effect on general-purpose bits, even when their pin value differs from the buffer.
- R6: When `wr_en` and `xfer_pulse` are high in the same cycle, a PWM-mode bit takes the newly written `wr_data` bit, not the old buffer bit.
- R7: `rd_data[6:0]` returns the pin register and not the buffer, and `rd_data[7]` reads 0.
- R8: A write loads all seven buffer bits, whatever their mode. A bit that is later switched to PWM mode transfers that stored value.
- R9: With `wr_en` and `xfer_pulse` both low, the pin register holds its value, whatever `wr_data` and `pwm_mask` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for the port address |
| wr_data | input | 7 | CPU write data, bits 6..0 |
| pwm_mask | input | 7 | Per-bit mode: 1 = PWM (deferred), 0 = general-purpose (immediate) |
| xfer_pulse | input | 1 | Single-cycle transfer trigger from the timer |
| pin_out | output | 7 | Pin register, driving the port pins |
| rd_data | output | 8 | CPU read data: zero bit 7 over the pin register |

## Verification
A CPU write and a timer transfer pulse can fall in the same clock cycle. The bench forces this collision with the buffer deliberately holding a value different from the new write data, so taking the stale buffer bit would show on the pins. It forces the collision both with every bit in PWM mode and with a mixed mask, and then in a long pseudo-random run where strobe, pulse, mask and data change independently every cycle. A behavioural model applies the rule that the written value wins for PWM bits and that general-purpose bits ignore the pulse. The bench compares `pin_out` and `rd_data` with this model after every edge.

// File: rtl/pwmport_pkg.sv
package pwmport_pkg;
  typedef enum logic {
    BIT_GPIO = 1'b0,
    BIT_PWM  = 1'b1
  } bit_mode_e;

  localparam int unsigned DEF_PORT_W = 7;
  localparam int unsigned DEF_BUS_W  = 8;
endpackage

// File: rtl/pbuf_shadow.sv
module pbuf_shadow #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] shadow_q
);
  always_ff @(posedge clk) begin
    if (rst)        shadow_q <= '0;
    else if (wr_en) shadow_q <= wr_bits;
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (shadow_q == $past(wr_bits))); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(shadow_q)); // R8
endmodule

// File: rtl/pbuf_pinreg.sv
module pbuf_pinreg
  import pwmport_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_bits,
  input  logic [W-1:0] mode_mask,
  input  logic         xfer,
  input  logic [W-1:0] shadow_q,
  output logic [W-1:0] pin_q
);
  logic [W-1:0] pin_nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic is_pwm;
    assign is_pwm = (bit_mode_e'(mode_mask[i]) == BIT_PWM);
    assign pin_nxt[i] = is_pwm
      ? (xfer  ? (wr_en ? wr_bits[i] : shadow_q[i]) : pin_q[i])
      : (wr_en ? wr_bits[i] : pin_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_nxt;
  end

  AST_GP_WRITE_THRU: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((pin_q & ~$past(mode_mask)) == ($past(wr_bits) & ~$past(mode_mask)))); // R2

  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> (((pin_q ^ $past(pin_q)) & $past(mode_mask)) == '0)); // R3

  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wr_en) |=> ((pin_q & $past(mode_mask)) == ($past(shadow_q) & $past(mode_mask)))); // R4

  AST_GP_NO_XFER: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wr_en) |=> (((pin_q ^ $past(pin_q)) & ~$past(mode_mask)) == '0)); // R5

  AST_COLLIDE_NEW: assert property (@(posedge clk) disable iff (rst)
    (xfer && wr_en) |=> (pin_q == $past(wr_bits))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !wr_en) |=> $stable(pin_q)); // R9
endmodule

// File: rtl/pbuf_readback.sv
module pbuf_readback #(
  parameter int unsigned W     = 7,
  parameter int unsigned BUS_W = 8
) (
  input  logic [W-1:0]     pin_q,
  output logic [BUS_W-1:0] rd_data
);
  localparam int unsigned PAD_W = BUS_W - W;

  if (PAD_W > 0) begin : g_pad
    assign rd_data = {{PAD_W{1'b0}}, pin_q};
  end else begin : g_nopad
    assign rd_data = pin_q[BUS_W-1:0];
  end
endmodule

// File: rtl/pwm_port_buf.sv
module pwm_port_buf #(
  parameter int unsigned PORT_W = pwmport_pkg::DEF_PORT_W,
  parameter int unsigned BUS_W  = pwmport_pkg::DEF_BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] pwm_mask,
  input  logic              xfer_pulse,
  output logic [PORT_W-1:0] pin_out,
  output logic [BUS_W-1:0]  rd_data
);
  logic [PORT_W-1:0] shadow_q;
  logic [PORT_W-1:0] pin_q;

  pbuf_shadow #(.W(PORT_W)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_bits  (wr_data),
    .shadow_q (shadow_q)
  );

  pbuf_pinreg #(.W(PORT_W)) u_pin (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_bits   (wr_data),
    .mode_mask (pwm_mask),
    .xfer      (xfer_pulse),
    .shadow_q  (shadow_q),
    .pin_q     (pin_q)
  );

  pbuf_readback #(.W(PORT_W), .BUS_W(BUS_W)) u_rd (
    .pin_q   (pin_q),
    .rd_data (rd_data)
  );

  assign pin_out = pin_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pin_out == '0)); // R1
endmodule

// File: tb/sim_pwm_port_buf.sv
module sim_pwm_port_buf;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 7;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [PW-1:0] wr_data;
  logic [PW-1:0] pwm_mask;
  logic          xfer_pulse;
  logic [PW-1:0] pin_out;
  logic [BW-1:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int ref_sh;
  int ref_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_port_buf u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pwm_mask(pwm_mask), .xfer_pulse(xfer_pulse),
    .pin_out(pin_out), .rd_data(rd_data)
  );

  task automatic compare(input string tag);
    total++;
    if (int'(pin_out) != ref_pin || int'(rd_data) != ref_pin) begin
      bad++;
      $display("FAIL %s: pin_out=%02h rd_data=%02h expected=%02h",
               tag, pin_out, rd_data, ref_pin[7:0]);
    end
  endtask

  task automatic step(input bit we, input int d, input int m, input bit xf, input string tag);
    wr_en = we; wr_data = d[PW-1:0]; pwm_mask = m[PW-1:0]; xfer_pulse = xf;
    @(posedge clk);
    for (int i = 0; i < PW; i++) begin
      if (m[i]) begin
        if (xf) ref_pin[i] = we ? d[i] : ref_sh[i];
      end else if (we) begin
        ref_pin[i] = d[i];
      end
    end
    if (we) ref_sh = d & 'h7F;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_data = '1; pwm_mask = '1; xfer_pulse = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ref_sh = 0; ref_pin = 0;
    rst = 1'b0;
    compare("R1 reset");

    step(1, 'h55, 'h00, 0, "R2 gp write 55");
    step(1, 'h2A, 'h00, 0, "R2 gp write 2A");
    step(1, 'h7F, 'h00, 0, "R7 all ones, bit7 reads 0");
    step(0, 'h00, 'h3C, 0, "R9 idle, data and mask change");
    step(0, 'h11, 'h00, 0, "R9 idle again");

    step(1, 'h00, 'h0F, 0, "R3 pwm bits hold, gp bits write");
    step(0, 'h6B, 'h0F, 0, "R7 read shows pin, not buffer");
    step(0, 'h00, 'h0F, 1, "R4 transfer to pwm bits");

    step(1, 'h00, 'h00, 0, "R2 clear all");
    step(1, 'h7F, 'h70, 0, "R3 bits 6..4 held, low bits written");
    step(0, 'h00, 'h0F, 1, "R5 gp bits 6..4 ignore transfer");
    step(0, 'h00, 'h70, 1, "R8 buffer kept value of then-gp bits");

    step(1, 'h7F, 'h00, 0, "R2 load ones");
    step(1, 'h2A, 'h7F, 1, "R6 write wins over stale buffer");
    step(1, 'h55, 'h7F, 0, "R3 buffer 55 pending");
    step(1, 'h0C, 'h33, 1, "R6 mixed mask collision");
    step(0, 'h00, 'h7F, 1, "R4 transfer after collision");

    for (int k = 0; k < 400; k++)
      step($urandom_range(0,1) == 1, int'($urandom_range(0,127)),
           int'($urandom_range(0,127)), $urandom_range(0,2) == 0, "R6 random mix");

    wr_en = 0; xfer_pulse = 0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; ref_sh = 0; ref_pin = 0;
    compare("R1 second reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule